// File: doc/BRIEF.md
# I/O Register Target with Single-Word Disconnect

This block is the target side of a 32-bit multiplexed address/data bus for a small bank of registers in I/O space. Each register can move only one word per transaction. The block watches the bus-cycle strobe `cyc_n`, the initiator-ready strobe `mrdy_n`, the shared address/data lines and the command/byte-enable lines. It claims I/O read and I/O write commands that fall inside its address window. It answers with a select strobe, a target-ready strobe and a stop strobe, and it drives read data back onto the address/data lines.

By default every claimed access ends with a disconnect that carries data: the stop strobe is asserted together with target-ready. One word completes and the initiator is told to leave. If the initiator still holds the cycle strobe after that word because it wanted a burst, the block moves to a backoff state. There it keeps stop asserted and withholds ready until the cycle strobe drops. A build-time option makes writes complete with ready alone and refuse any following data phase with stop.

Transactions meant for other devices put the block into a bus-busy state, which it leaves only when the bus is fully idle. A new claimed address phase that comes straight after the block's own final data phase is accepted with no idle cycle between.

Top module: `iotgt_ctrl`

## Requirements
- R1: After reset, `ctl_oe` and `ad_oe` are low and every register reads back as zero.
- R2: An address phase (the first cycle with `cyc_n` low while the bus was idle or just after a final data phase) is claimed only when `cmd_be_n` is 4'b0010 (I/O read) or 4'b0011 (I/O write) and `ad_in[31:4]` equals `BASE_ADDR[31:4]`. `ad_in[3:2]` then selects one of four registers. Any other address phase is never claimed.
- R3: For a claimed address phase sampled at clock edge k, `sel_n` and `srdy_n` are low and `ctl_oe` is high from the cycle after edge k+1. In the cycle between, `ctl_oe` and `ad_oe` stay low. `ad_oe` is high only on reads.
- R4: A word moves only on a clock edge where `srdy_n` and `mrdy_n` are both low. The initiator may hold `mrdy_n` high for any number of cycles in the data phase, and no word moves during those cycles.
- R5: With `WR_NODATA` = 0, and for reads in either mode, `halt_n` is low in every cycle in which `srdy_n` is low. This includes a true single transfer where `cyc_n` is already high when `mrdy_n` asserts.
- R6: If `cyc_n` is low on the edge where a word moves, then from the next cycle `srdy_n` is high, `halt_n` is low and `sel_n` is low. The block holds this until it samples `cyc_n` high.
- R7: At most one word moves per transaction. After the transfer edge, `srdy_n` stays high until the next address phase.
- R8: On a write, a byte lane of the selected register is updated only when its active-low enable in `cmd_be_n` is low during the transfer. A later read returns the updated register.
- R9: After the last data phase, `sel_n`, `srdy_n` and `halt_n` are driven high with `ctl_oe` high for exactly one cycle. After that `ctl_oe` is low unless a new claimed transaction starts.
- R10: A claimed address phase presented in the cycle right after the block's final data phase (`cyc_n` low with no idle cycle) is accepted with the same timing as R3.
- R11: After an unclaimed address phase, `ctl_oe` stays low until `cyc_n` and `mrdy_n` have both been sampled high. Address patterns that would match, seen during that time, are ignored.
- R12: With `WR_NODATA` = 1, a write word completes with `srdy_n` low and `halt_n` high, and any data phase after it is refused as in R6. Reads still follow R5, and the write still updates the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ad_in | input | 32 | Address/data lines as sampled from the bus |
| ad_out | output | 32 | Read data for the address/data lines |
| ad_oe | output | 1 | Enable for driving `ad_out` onto the bus |
| cmd_be_n | input | 4 | Command in the address phase, active-low byte enables in data phases |
| cyc_n | input | 1 | Initiator bus-cycle strobe, low while more data phases follow |
| mrdy_n | input | 1 | Initiator ready strobe, low when the initiator can move a word |
| sel_n | output | 1 | Target select strobe, low when the transaction is claimed |
| srdy_n | output | 1 | Target ready strobe |
| halt_n | output | 1 | Target stop strobe asking the initiator to end the transaction |
| ctl_oe | output | 1 | Enable for driving `sel_n`, `srdy_n` and `halt_n` |

## Verification
The assertions assume a well-behaved initiator. It raises `cyc_n` only while `mrdy_n` is low or on an idle bus, never abandons a claimed transaction before a word moves or a stop is honoured, and keeps `mrdy_n` asserted until its final data phase completes. The stimulus keeps to these rules: every transaction, claimed or foreign, is driven by tasks that step through address, wait, data, backoff and turnaround phases in that legal order. Foreign cycles end with `cyc_n` high and `mrdy_n` low before the bus goes idle. Fast back-to-back starts are issued only right after the block's own final data phase.

// File: rtl/iotgt_pkg.sv
`timescale 1ns/1ps
package iotgt_pkg;

  // bus command codes decoded in the address phase
  localparam logic [3:0] CMD_IORD = 4'b0010;
  localparam logic [3:0] CMD_IOWR = 4'b0011;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // bus idle, watching for an address phase
    ST_BUSY = 3'd1,  // someone else's transaction in progress
    ST_DEC  = 3'd2,  // claimed, medium decode slot, outputs released
    ST_DATA = 3'd3,  // select + ready (+ stop) asserted
    ST_BACK = 3'd4,  // word done, stop held until the cycle strobe drops
    ST_TURN = 3'd5   // outputs driven high for one clock
  } tstate_e;

endpackage

// File: rtl/iotgt_rstsync.sv
`timescale 1ns/1ps
module iotgt_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= {sh_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/iotgt_decode.sv
`timescale 1ns/1ps
module iotgt_decode
  import iotgt_pkg::*;
#(
  parameter int          DW        = 32,
  parameter int          IDX_W     = 2,
  parameter logic [31:0] BASE_ADDR = 32'h0000_0C00
) (
  input  logic [DW-1:0]    ad,
  input  logic [3:0]       cmd,
  output logic             hit,
  output logic             wr,
  output logic [IDX_W-1:0] idx
);

  localparam int LSB = 2 + IDX_W;

  logic cmd_rd;
  logic cmd_wr;
  logic win_match;
  logic unused_lo;

  assign cmd_rd    = (cmd == CMD_IORD);
  assign cmd_wr    = (cmd == CMD_IOWR);
  assign win_match = (ad[DW-1:LSB] == BASE_ADDR[DW-1:LSB]);
  assign hit       = (cmd_rd | cmd_wr) & win_match;
  assign wr        = cmd_wr;
  assign idx       = ad[LSB-1:2];
  assign unused_lo = ^ad[1:0];

endmodule

// File: rtl/iotgt_fsm.sv
`timescale 1ns/1ps
module iotgt_fsm
  import iotgt_pkg::*;
#(
  parameter bit WR_NODATA = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_n,
  input  logic mrdy_n,
  input  logic dec_hit,
  input  logic dec_wr,
  output logic claim,
  output logic wr_xfer,
  output logic sel_n,
  output logic srdy_n,
  output logic halt_n,
  output logic ctl_oe,
  output logic ad_oe,
  output logic busy
);

  tstate_e st_q;
  tstate_e st_d;
  logic    wr_q;
  logic    addr_ph;
  logic    in_data;
  logic    in_back;
  logic    in_turn;
  logic    nodata_wr;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    addr_ph = 1'b0;
    case (st_q)
      ST_IDLE, ST_TURN: begin
        if (!cyc_n) begin
          addr_ph = 1'b1;
          st_d    = dec_hit ? ST_DEC : ST_BUSY;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_BUSY: begin
        if (cyc_n && mrdy_n) st_d = ST_IDLE;
      end
      ST_DEC: begin
        st_d = ST_DATA;
      end
      ST_DATA: begin
        if (!mrdy_n) st_d = cyc_n ? ST_TURN : ST_BACK;
      end
      ST_BACK: begin
        if (cyc_n) st_d = ST_TURN;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign claim = addr_ph & dec_hit;

  // state and direction registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      wr_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (claim) wr_q <= dec_wr;
    end
  end

  // outputs decoded from state
  assign in_data   = (st_q == ST_DATA);
  assign in_back   = (st_q == ST_BACK);
  assign in_turn   = (st_q == ST_TURN);
  assign nodata_wr = WR_NODATA & wr_q;

  assign sel_n   = ~(in_data | in_back);
  assign srdy_n  = ~in_data;
  assign halt_n  = ~(in_back | (in_data & ~nodata_wr));
  assign ctl_oe  = in_data | in_back | in_turn;
  assign ad_oe   = ~wr_q & (in_data | in_back);
  assign wr_xfer = in_data & ~mrdy_n & wr_q;
  assign busy    = (st_q == ST_BUSY);

endmodule

// File: rtl/iotgt_regs.sv
`timescale 1ns/1ps
module iotgt_regs #(
  parameter int DW    = 32,
  parameter int NREG  = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [IDX_W-1:0] idx_d,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  input  logic [DW/8-1:0]  be_n,
  output logic [DW-1:0]    rdata
);

  localparam int NB = DW / 8;

  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    words [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (ld) begin
      idx_q <= idx_d;
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [DW-1:0] word_q;
    logic [DW-1:0] word_d;
    logic          we;

    assign we = wr_en && (idx_q == IDX_W'(r));

    always_comb begin
      word_d = word_q;
      for (int b = 0; b < NB; b++) begin
        if (!be_n[b]) word_d[8*b +: 8] = wdata[8*b +: 8];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (we) begin
        word_q <= word_d;
      end
    end

    assign words[r] = word_q;
  end

  assign rdata = words[idx_q];

endmodule

// File: rtl/iotgt_ctrl.sv
`timescale 1ns/1ps
module iotgt_ctrl
  import iotgt_pkg::*;
#(
  parameter int          DW        = 32,
  parameter int          NREG      = 4,
  parameter logic [31:0] BASE_ADDR = 32'h0000_0C00,
  parameter bit          WR_NODATA = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   ad_in,
  output logic [DW-1:0]   ad_out,
  output logic            ad_oe,
  input  logic [DW/8-1:0] cmd_be_n,
  input  logic            cyc_n,
  input  logic            mrdy_n,
  output logic            sel_n,
  output logic            srdy_n,
  output logic            halt_n,
  output logic            ctl_oe
);

  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic             rst_q_n;
  logic             dec_hit;
  logic             dec_wr;
  logic [IDX_W-1:0] dec_idx;
  logic             claim;
  logic             wr_xfer;
  logic             st_busy;

  iotgt_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  iotgt_decode #(
    .DW        (DW),
    .IDX_W     (IDX_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_dec (
    .ad  (ad_in),
    .cmd (cmd_be_n[3:0]),
    .hit (dec_hit),
    .wr  (dec_wr),
    .idx (dec_idx)
  );

  iotgt_fsm #(.WR_NODATA(WR_NODATA)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .cyc_n   (cyc_n),
    .mrdy_n  (mrdy_n),
    .dec_hit (dec_hit),
    .dec_wr  (dec_wr),
    .claim   (claim),
    .wr_xfer (wr_xfer),
    .sel_n   (sel_n),
    .srdy_n  (srdy_n),
    .halt_n  (halt_n),
    .ctl_oe  (ctl_oe),
    .ad_oe   (ad_oe),
    .busy    (st_busy)
  );

  iotgt_regs #(
    .DW    (DW),
    .NREG  (NREG),
    .IDX_W (IDX_W)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_q_n),
    .ld    (claim),
    .idx_d (dec_idx),
    .wr_en (wr_xfer),
    .wdata (ad_in),
    .be_n  (cmd_be_n),
    .rdata (ad_out)
  );

endmodule

// File: rtl/iotgt_chk.sv
`timescale 1ns/1ps
module iotgt_chk (
  input logic clk,
  input logic rst_n,
  input logic cyc_n,
  input logic mrdy_n,
  input logic sel_n,
  input logic srdy_n,
  input logic halt_n,
  input logic ctl_oe,
  input logic ad_oe,
  input logic busy
);

  // R7
  one_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!srdy_n && !mrdy_n) |=> srdy_n);

  // R6
  backoff_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!srdy_n && !mrdy_n && !cyc_n) |=> (srdy_n && !halt_n && !sel_n));

  // R6
  backoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srdy_n && !halt_n && !cyc_n) |=> (srdy_n && !halt_n));

  // R9
  release_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_oe) |-> ($past(sel_n) && $past(srdy_n) && $past(halt_n)));

  // R3
  ad_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (!sel_n && ctl_oe));

  // R5
  rd_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && !srdy_n) |-> !halt_n);

  // R11
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!ctl_oe && !ad_oe));

  // R4
  ready_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !srdy_n |-> (!sel_n && ctl_oe));

endmodule

bind iotgt_ctrl iotgt_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cyc_n  (cyc_n),
  .mrdy_n (mrdy_n),
  .sel_n  (sel_n),
  .srdy_n (srdy_n),
  .halt_n (halt_n),
  .ctl_oe (ctl_oe),
  .ad_oe  (ad_oe),
  .busy   (st_busy)
);

// File: tb/iotgt_ctrl_bench.sv
`timescale 1ns/1ps
module iotgt_ctrl_bench;

  localparam int          NREG = 4;
  localparam logic [31:0] BASE = 32'h0000_0C00;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ad_in;
  logic [3:0]  be_n;
  logic        cyc_n;
  logic        mrdy_n;

  logic [31:0] ado_a, ado_b;
  logic        adoe_a, sel_a, srdy_a, halt_a, oe_a;
  logic        adoe_b, sel_b, srdy_b, halt_b, oe_b;

  int checks = 0;
  int fails  = 0;
  int xa = 0;
  int xb = 0;
  logic [31:0] rd_a, rd_b;
  logic        hz_a, hz_b;
  logic [31:0] mdl [NREG];

  always #10 clk = ~clk;

  iotgt_ctrl #(.BASE_ADDR(BASE), .WR_NODATA(1'b0)) u_iotgt_ctrl (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .ad_out(ado_a), .ad_oe(adoe_a),
    .cmd_be_n(be_n), .cyc_n(cyc_n), .mrdy_n(mrdy_n),
    .sel_n(sel_a), .srdy_n(srdy_a), .halt_n(halt_a), .ctl_oe(oe_a)
  );

  iotgt_ctrl #(.BASE_ADDR(BASE), .WR_NODATA(1'b1)) u_iotgt_ctrl_wnd (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .ad_out(ado_b), .ad_oe(adoe_b),
    .cmd_be_n(be_n), .cyc_n(cyc_n), .mrdy_n(mrdy_n),
    .sel_n(sel_b), .srdy_n(srdy_b), .halt_n(halt_b), .ctl_oe(oe_b)
  );

  // transfer monitor: samples halfway between falling and rising edge
  always begin
    @(negedge clk);
    #5;
    if (!srdy_a && !mrdy_n) begin
      xa++;
      rd_a = ado_a;
      hz_a = halt_a;
    end
    if (!srdy_b && !mrdy_n) begin
      xb++;
      rd_b = ado_b;
      hz_b = halt_b;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // one claimed transaction; starts at a falling edge with the bus idle or in turnaround
  task automatic txn(input int idx, input bit rd, input logic [31:0] wd, input logic [3:0] ben,
                     input int waits, input bit burst, input bit b2b, input bit fb);
    int    n0;
    int    nb0;
    string lbl;
    lbl = fb ? "R10" : "R3";
    cyc_n  = 1'b0;
    mrdy_n = 1'b1;
    ad_in  = BASE | (32'(idx) << 2);
    be_n   = rd ? 4'b0010 : 4'b0011;
    @(negedge clk);
    chk(!oe_a && !adoe_a && !oe_b, {lbl, " no drive in decode slot"}, {30'd0, oe_a, adoe_a}, 32'd0);
    ad_in = rd ? 32'hA5A5_5A5A : wd;
    be_n  = rd ? 4'b0000 : ben;
    if (waits == 0) begin
      mrdy_n = 1'b0;
      cyc_n  = burst ? 1'b0 : 1'b1;
    end
    @(negedge clk);
    chk(!sel_a && oe_a && !srdy_a && (adoe_a == rd), {lbl, " claim timing"},
        {28'd0, sel_a, oe_a, srdy_a, adoe_a}, {28'd0, 1'b0, 1'b1, 1'b0, rd});
    chk(!halt_a, "R5 stop with ready", {31'd0, halt_a}, 32'd0);
    chk(!srdy_b && (halt_b == !rd), "R12 stop choice by direction", {31'd0, halt_b}, {31'd0, !rd});
    n0  = xa;
    nb0 = xb;
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      chk((xa == n0) && !srdy_a, "R4 no word during wait", 32'(xa), 32'(n0));
    end
    if (waits > 0) begin
      mrdy_n = 1'b0;
      cyc_n  = burst ? 1'b0 : 1'b1;
    end
    @(negedge clk);
    chk(xa == n0 + 1, "R4 word moves with both ready", 32'(xa), 32'(n0 + 1));
    chk(xb == nb0 + 1, "R12 word moves in alternate mode", 32'(xb), 32'(nb0 + 1));
    chk(hz_a == 1'b0, "R5 disconnect with data", {31'd0, hz_a}, 32'd0);
    chk(hz_b == !rd, "R12 write completes without stop", {31'd0, hz_b}, {31'd0, !rd});
    if (!rd) begin
      for (int b = 0; b < 4; b++) begin
        if (!ben[b]) mdl[idx][8*b +: 8] = wd[8*b +: 8];
      end
    end else begin
      chk(rd_a == mdl[idx], "R8 readback", rd_a, mdl[idx]);
      chk(rd_b == mdl[idx], "R12 register written in alternate mode", rd_b, mdl[idx]);
    end
    if (burst) begin
      ad_in = ~wd;
      for (int k = 0; k < 3; k++) begin
        chk(srdy_a && !halt_a && !sel_a && srdy_b && !halt_b, "R6 backoff held",
            {28'd0, srdy_a, halt_a, sel_a, halt_b}, {28'd0, 1'b1, 1'b0, 1'b0, 1'b0});
        chk(xa == n0 + 1, "R7 single word per transaction", 32'(xa), 32'(n0 + 1));
        if (k < 2) @(negedge clk);
      end
      cyc_n = 1'b1;
      @(negedge clk);
    end
    mrdy_n = 1'b1;
    chk(sel_a && srdy_a && halt_a && oe_a && !adoe_a, "R9 driven high one clock",
        {27'd0, sel_a, srdy_a, halt_a, oe_a, adoe_a}, {27'd0, 5'b11110});
    chk(xa == n0 + 1, "R7 no second word", 32'(xa), 32'(n0 + 1));
    if (!b2b) begin
      @(negedge clk);
      chk(!oe_a && !oe_b && !adoe_a, "R9 outputs released", {30'd0, oe_a, oe_b}, 32'd0);
    end
  endtask

  // a transaction for another device; starts and ends with the bus idle
  task automatic foreign(input logic [31:0] addr, input logic [3:0] cmd);
    cyc_n  = 1'b0;
    mrdy_n = 1'b1;
    ad_in  = addr;
    be_n   = cmd;
    @(negedge clk);
    chk(!oe_a && !oe_b, "R2 unclaimed address phase", {31'd0, oe_a}, 32'd0);
    ad_in  = BASE;
    be_n   = 4'b0010;
    mrdy_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!oe_a && !oe_b && !adoe_a, "R11 matching pattern ignored while busy", {31'd0, oe_a}, 32'd0);
    end
    cyc_n = 1'b1;
    @(negedge clk);
    chk(!oe_a && !oe_b, "R11 quiet in final foreign phase", {31'd0, oe_a}, 32'd0);
    mrdy_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    finish_up();
  end

  initial begin
    logic [31:0] wd;
    logic [3:0]  bv;
    rst_n  = 1'b0;
    cyc_n  = 1'b1;
    mrdy_n = 1'b1;
    ad_in  = '0;
    be_n   = 4'hF;
    for (int i = 0; i < NREG; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    chk(!oe_a && !adoe_a && !oe_b, "R1 no drive in reset", {30'd0, oe_a, adoe_a}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!oe_a && !adoe_a, "R1 no drive after reset", {30'd0, oe_a, adoe_a}, 32'd0);
    for (int i = 0; i < NREG; i++) begin
      txn(i, 1'b1, 32'd0, 4'h0, 0, 1'b0, 1'b0, 1'b0);
      chk(rd_a == 32'd0, "R1 register zero after reset", rd_a, 32'd0);
    end

    for (int idx = 0; idx < NREG; idx++) begin
      for (int be = 0; be < 16; be++) begin
        bv = 4'(be);
        wd = 32'h1357_9BDF * 32'(idx * 16 + be + 1);
        txn(idx, 1'b0, wd, bv, be % 3, bv[0], (be % 4 == 1) || (be % 4 == 2), 1'b0);
        txn(idx, 1'b1, 32'd0, 4'h0, (be + 1) % 3, bv[1], 1'b0, (be % 4 == 1) || (be % 4 == 2));
      end
      foreign(BASE + 32'h10, 4'b0010);
      foreign(BASE | (32'(idx) << 2), 4'b0110);
      foreign(BASE | (32'(idx) << 2), 4'b0111);
    end

    // long initiator wait before the only word
    txn(2, 1'b1, 32'd0, 4'h0, 6, 1'b0, 1'b0, 1'b0);
    // every register holds its own value
    for (int i = 0; i < NREG; i++) begin
      txn(i, 1'b1, 32'd0, 4'h0, 1, 1'b0, 1'b0, 1'b0);
      chk(rd_a == mdl[i], "R2 register select", rd_a, mdl[i]);
    end
    finish_up();
  end

endmodule